// File: doc/BRIEF.md
# Three-Level Translation Table Walker

This block serves translation-buffer misses. A miss request arrives with a 32-bit virtual address and a context number. The walker first reads a root pointer from a context table: it adds the context number times four to a context table base address. It then descends through three levels of tables, reading one 32-bit word at a time over a plain request/response memory port. Each word it fetches is classified by its two low bits. A word is either a pointer to the next table or a leaf translation. Anything else ends the walk with a fault.

A leaf at the third level maps a 4 KiB page. A leaf found at the first or second level ends the walk early and maps a large region. In that case the virtual index bits below that level pass straight into the physical address. The walker returns the leaf word, the physical address and the level it was found at, as a one-cycle refill pulse. When the walk is abandoned, it returns a one-cycle fault pulse naming the level that failed. Only one walk runs at a time. A new miss waits on a ready/valid handshake.

Top module: `ptw_walker`

## Requirements
- R1: The virtual address is split as index1 = bits 31:24, index2 = bits 23:18, index3 = bits 17:12 and offset = bits 11:0. A leaf found at level 3 gives done_paddr = {leaf[31:12], vaddr[11:0]}.
- R2: The first memory read of every walk is at ctx_base + 4 × req_ctx, using the values presented when the request is accepted.
- R3: The tables are read in the order level 1, level 2, level 3. A pointer word p gives the next read address {p[31:2], 2'b00} + 4 × (that level's index).
- R4: Bits 1:0 of every fetched word select its kind: 0 = invalid, 1 = pointer, 2 = leaf, 3 = reserved. An invalid or reserved word ends the walk with fault_valid, and fault_level names the level read (0 = context table, 1 to 3 = table levels).
- R5: A leaf at level 1 gives done_paddr = {leaf[31:24], vaddr[23:0]}. A leaf at level 2 gives done_paddr = {leaf[31:18], vaddr[17:0]}.
- R6: A pointer fetched at level 3 is a fault at level 3. A leaf fetched from the context table is a fault at level 0.
- R7: req_ready is high only while no walk is in progress. After a request is accepted it drops on the next cycle, and a request held during a walk starts no memory read until it is accepted.
- R8: A finished walk raises done_valid for exactly one cycle, with done_pte equal to the leaf word and done_level equal to 1, 2 or 3. done_valid and fault_valid are never high together, and req_ready is high in the cycle either pulse appears.
- R9: After reset, req_ready is high and mem_req_valid, done_valid and fault_valid are low.
- R10: Each memory read is a one-cycle mem_req_valid pulse at a word-aligned address, and no new read is issued before the previous response returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Miss request present |
| req_ready | output | 1 | Walker idle, request accepted when valid |
| req_vaddr | input | 32 | Virtual address to translate |
| req_ctx | input | 4 | Context number of the access |
| ctx_base | input | 32 | Byte address of the context table |
| mem_req_valid | output | 1 | One-cycle word read request |
| mem_req_addr | output | 32 | Byte address of the word to read |
| mem_rsp_valid | input | 1 | Read data present |
| mem_rsp_data | input | 32 | Word read from memory |
| done_valid | output | 1 | Refill pulse |
| done_pte | output | 32 | Leaf word that ended the walk |
| done_paddr | output | 32 | Translated physical address |
| done_level | output | 2 | Level at which the leaf was found |
| fault_valid | output | 1 | Fault pulse |
| fault_level | output | 2 | Level whose word caused the fault |

## Verification
The walks used are:
- full three-level walks, to show the index slicing and the pointer arithmetic at every level;
- early leaves at levels 1 and 2, to show that the pass-through mask widens with each level;
- invalid, reserved and unmapped words at the context table and at levels 2 and 3, to show which level a fault reports;
- a pointer at the last level and a leaf in the context table, which have a valid kind but are misplaced.

Context 15 is used together with all-ones indices to exercise the top of every field. Requests are also sent back to back with their valid held during a walk, under memory latencies of 0, 1 and 3 cycles. These runs show that a waiting miss starts no reads, because every read address is compared in order against the bench's own walk.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

  typedef enum logic [1:0] {
    ENT_INVALID = 2'd0,
    ENT_PTR     = 2'd1,
    ENT_LEAF    = 2'd2,
    ENT_RSVD    = 2'd3
  } ent_kind_e;

  typedef enum logic {
    WS_IDLE = 1'b0,
    WS_WAIT = 1'b1
  } walk_state_e;

  localparam logic [1:0] LVL_CTX  = 2'd0;
  localparam logic [1:0] LVL_LAST = 2'd3;

endpackage

// File: rtl/ptw_entry_decode.sv
module ptw_entry_decode
  import ptw_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0]   entry,
  output ent_kind_e      kind,
  output logic [W-1:0]   next_base
);
  // Kind lives in the two low bits; a pointer is word aligned.
  assign kind      = ent_kind_e'(entry[1:0]);
  assign next_base = {entry[W-1:2], 2'b00};
endmodule

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
  parameter int W      = 32,
  parameter int CTX_W  = 4,
  parameter int OFF_W  = 12,
  parameter int IDX1_W = 8,
  parameter int IDX2_W = 6,
  parameter int IDX3_W = 6
) (
  input  logic [W-1:0]       base,
  input  logic [W-1:OFF_W]   vpn,
  input  logic [CTX_W-1:0]   ctx,
  input  logic [1:0]         level,
  output logic [W-1:0]       addr
);
  localparam int L3_LSB = OFF_W;
  localparam int L2_LSB = L3_LSB + IDX3_W;
  localparam int L1_LSB = L2_LSB + IDX2_W;

  logic [W-1:0] idx_ext;

  always_comb begin
    unique case (level)
      2'd0:    idx_ext = W'(ctx);
      2'd1:    idx_ext = W'(vpn[L1_LSB +: IDX1_W]);
      2'd2:    idx_ext = W'(vpn[L2_LSB +: IDX2_W]);
      default: idx_ext = W'(vpn[L3_LSB +: IDX3_W]);
    endcase
    addr = base + (idx_ext << 2);
  end
endmodule

// File: rtl/ptw_paddr_merge.sv
module ptw_paddr_merge #(
  parameter int W      = 32,
  parameter int OFF_W  = 12,
  parameter int IDX2_W = 6,
  parameter int IDX3_W = 6
) (
  input  logic [W-1:0] leaf,
  input  logic [W-1:0] vaddr,
  input  logic [1:0]   level,
  output logic [W-1:0] paddr
);
  localparam int L3_LSB = OFF_W;
  localparam int L2_LSB = L3_LSB + IDX3_W;
  localparam int L1_LSB = L2_LSB + IDX2_W;

  // One pass-through mask per leaf level, built from the field widths.
  logic [W-1:0] lvl_mask [1:3];
  for (genvar g = 1; g <= 3; g++) begin : g_mask
    localparam int LSB = (g == 1) ? L1_LSB : ((g == 2) ? L2_LSB : L3_LSB);
    assign lvl_mask[g] = (W'(1) << LSB) - W'(1);
  end

  logic [W-1:0] mask;
  always_comb begin
    unique case (level)
      2'd1:    mask = lvl_mask[1];
      2'd2:    mask = lvl_mask[2];
      default: mask = lvl_mask[3];
    endcase
    paddr = (leaf & ~mask) | (vaddr & mask);
  end
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
  import ptw_pkg::*;
#(
  parameter int CTX_W  = 4,
  parameter int IDX1_W = 8,
  parameter int IDX2_W = 6,
  parameter int IDX3_W = 6,
  parameter int OFF_W  = 12
) (
  input  logic                                   clk,
  input  logic                                   rst,
  input  logic                                   req_valid,
  output logic                                   req_ready,
  input  logic [IDX1_W+IDX2_W+IDX3_W+OFF_W-1:0]  req_vaddr,
  input  logic [CTX_W-1:0]                       req_ctx,
  input  logic [IDX1_W+IDX2_W+IDX3_W+OFF_W-1:0]  ctx_base,
  output logic                                   mem_req_valid,
  output logic [IDX1_W+IDX2_W+IDX3_W+OFF_W-1:0]  mem_req_addr,
  input  logic                                   mem_rsp_valid,
  input  logic [IDX1_W+IDX2_W+IDX3_W+OFF_W-1:0]  mem_rsp_data,
  output logic                                   done_valid,
  output logic [IDX1_W+IDX2_W+IDX3_W+OFF_W-1:0]  done_pte,
  output logic [IDX1_W+IDX2_W+IDX3_W+OFF_W-1:0]  done_paddr,
  output logic [1:0]                             done_level,
  output logic                                   fault_valid,
  output logic [1:0]                             fault_level
);
  localparam int W = IDX1_W + IDX2_W + IDX3_W + OFF_W;

  walk_state_e  state;
  logic [1:0]   lvl;
  logic [W-1:0] va_q;

  ent_kind_e    kind;
  logic [W-1:0] next_base;
  logic [W-1:0] gen_base;
  logic [W-1:0] gen_vaddr;
  logic [1:0]   gen_lvl;
  logic [W-1:0] gen_addr;
  logic [W-1:0] leaf_paddr;

  assign req_ready = (state == WS_IDLE);

  // Idle: first read comes from the context table; waiting: next table.
  assign gen_base  = req_ready ? ctx_base  : next_base;
  assign gen_vaddr = req_ready ? req_vaddr : va_q;
  assign gen_lvl   = req_ready ? LVL_CTX   : lvl + 2'd1;

  ptw_entry_decode #(.W(W)) u_dec (
    .entry     (mem_rsp_data),
    .kind      (kind),
    .next_base (next_base)
  );

  ptw_addr_gen #(
    .W(W), .CTX_W(CTX_W), .OFF_W(OFF_W),
    .IDX1_W(IDX1_W), .IDX2_W(IDX2_W), .IDX3_W(IDX3_W)
  ) u_agen (
    .base  (gen_base),
    .vpn   (gen_vaddr[W-1:OFF_W]),
    .ctx   (req_ctx),
    .level (gen_lvl),
    .addr  (gen_addr)
  );

  ptw_paddr_merge #(
    .W(W), .OFF_W(OFF_W), .IDX2_W(IDX2_W), .IDX3_W(IDX3_W)
  ) u_merge (
    .leaf  (mem_rsp_data),
    .vaddr (va_q),
    .level (lvl),
    .paddr (leaf_paddr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state         <= WS_IDLE;
      lvl           <= LVL_CTX;
      va_q          <= '0;
      mem_req_valid <= 1'b0;
      mem_req_addr  <= '0;
      done_valid    <= 1'b0;
      done_pte      <= '0;
      done_paddr    <= '0;
      done_level    <= '0;
      fault_valid   <= 1'b0;
      fault_level   <= '0;
    end else begin
      mem_req_valid <= 1'b0;
      done_valid    <= 1'b0;
      fault_valid   <= 1'b0;
      unique case (state)
        WS_IDLE: begin
          if (req_valid) begin
            va_q          <= req_vaddr;
            lvl           <= LVL_CTX;
            mem_req_valid <= 1'b1;
            mem_req_addr  <= gen_addr;
            state         <= WS_WAIT;
          end
        end
        WS_WAIT: begin
          if (mem_rsp_valid) begin
            unique case (kind)
              ENT_PTR: begin
                if (lvl == LVL_LAST) begin
                  fault_valid <= 1'b1;
                  fault_level <= lvl;
                  state       <= WS_IDLE;
                end else begin
                  lvl           <= lvl + 2'd1;
                  mem_req_valid <= 1'b1;
                  mem_req_addr  <= gen_addr;
                end
              end
              ENT_LEAF: begin
                if (lvl == LVL_CTX) begin
                  fault_valid <= 1'b1;
                  fault_level <= lvl;
                end else begin
                  done_valid <= 1'b1;
                  done_pte   <= mem_rsp_data;
                  done_paddr <= leaf_paddr;
                  done_level <= lvl;
                end
                state <= WS_IDLE;
              end
              default: begin
                fault_valid <= 1'b1;
                fault_level <= lvl;
                state       <= WS_IDLE;
              end
            endcase
          end
        end
        default: state <= WS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk (
  input logic       clk,
  input logic       rst,
  input logic       req_valid,
  input logic       req_ready,
  input logic       mem_req_valid,
  input logic [1:0] mem_req_addr_lo,
  input logic       done_valid,
  input logic [1:0] done_level,
  input logic       fault_valid
);
  assert_busy_after_accept_R7: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);

  assert_read_only_when_busy_R7: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |-> !req_ready);

  assert_result_exclusive_R8: assert property (@(posedge clk) disable iff (rst)
    !(done_valid && fault_valid));

  assert_ready_with_result_R8: assert property (@(posedge clk) disable iff (rst)
    (done_valid || fault_valid) |-> req_ready);

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    done_valid |=> !done_valid);

  assert_leaf_not_ctx_R6: assert property (@(posedge clk) disable iff (rst)
    done_valid |-> (done_level != 2'd0));

  assert_read_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |=> !mem_req_valid);

  assert_read_aligned_R10: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |-> (mem_req_addr_lo == 2'b00));
endmodule

bind ptw_walker ptw_walker_chk u_chk (
  .clk             (clk),
  .rst             (rst),
  .req_valid       (req_valid),
  .req_ready       (req_ready),
  .mem_req_valid   (mem_req_valid),
  .mem_req_addr_lo (mem_req_addr[1:0]),
  .done_valid      (done_valid),
  .done_level      (done_level),
  .fault_valid     (fault_valid)
);

// File: tb/tb_ptw_walker.sv
module tb_ptw_walker;
  localparam logic [31:0] CB = 32'h0001_0000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic [3:0]  req_ctx = '0;
  logic [31:0] ctx_base = CB;
  logic        mem_req_valid;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        done_valid;
  logic [31:0] done_pte;
  logic [31:0] done_paddr;
  logic [1:0]  done_level;
  logic        fault_valid;
  logic [1:0]  fault_level;

  always #4 clk = ~clk;

  ptw_walker dut (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .req_ctx(req_ctx), .ctx_base(ctx_base),
    .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .done_valid(done_valid), .done_pte(done_pte), .done_paddr(done_paddr),
    .done_level(done_level), .fault_valid(fault_valid), .fault_level(fault_level)
  );

  typedef struct {
    bit          is_fault;
    logic [1:0]  lvl;
    logic [31:0] pte;
    logic [31:0] pa;
    string       tag;
  } res_t;

  typedef struct {
    logic [31:0] a;
    bit          first;
  } rd_t;

  res_t exp_q[$];
  rd_t  rd_q[$];
  logic [31:0] mem_arr [logic [31:0]];

  int checks = 0;
  int fails  = 0;
  int lat    = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] rd(input logic [31:0] a);
    return mem_arr.exists(a) ? mem_arr[a] : 32'h0;
  endfunction

  function automatic logic [31:0] mkva(input logic [7:0] i1, input logic [5:0] i2,
                                       input logic [5:0] i3, input logic [11:0] off);
    return {i1, i2, i3, off};
  endfunction

  // Bench-side walk derived from the requirements.
  task automatic model(input logic [3:0] ctx, input logic [31:0] va, input string tag);
    res_t r;
    logic [31:0] base, a, ent, idx, mask;
    int lvl;
    bit stop;
    rd_t ri;
    base = CB; lvl = 0; stop = 0;
    r.is_fault = 0; r.lvl = 0; r.pte = 0; r.pa = 0; r.tag = tag;
    while (!stop) begin
      case (lvl)
        0: idx = {28'h0, ctx};
        1: idx = {24'h0, va[31:24]};
        2: idx = {26'h0, va[23:18]};
        default: idx = {26'h0, va[17:12]};
      endcase
      a = base + (idx << 2);
      ri.a = a; ri.first = (lvl == 0);
      rd_q.push_back(ri);
      ent = rd(a);
      stop = 1;
      if (ent[1:0] == 2'd1 && lvl != 3) begin
        base = {ent[31:2], 2'b00};
        lvl++;
        stop = 0;
      end else if (ent[1:0] == 2'd2 && lvl != 0) begin
        mask = (lvl == 1) ? 32'h00FF_FFFF : ((lvl == 2) ? 32'h0003_FFFF : 32'h0000_0FFF);
        r.lvl = 2'(lvl); r.pte = ent; r.pa = (ent & ~mask) | (va & mask);
      end else begin
        r.is_fault = 1; r.lvl = 2'(lvl);
      end
    end
    exp_q.push_back(r);
  endtask

  task automatic send(input logic [3:0] ctx, input logic [31:0] va, input string tag);
    model(ctx, va, tag);
    @(negedge clk);
    req_valid = 1'b1; req_ctx = ctx; req_vaddr = va;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready, "R7", "ready low after accept", {31'h0, req_ready}, 32'h0);
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  // Memory model with read-address scoreboard.
  logic        pend = 1'b0;
  logic [31:0] pend_addr = '0;
  int          dly = 0;
  always @(posedge clk) begin
    if (rst) begin
      mem_rsp_valid <= 1'b0; pend <= 1'b0; dly <= 0;
    end else begin
      mem_rsp_valid <= 1'b0;
      if (pend) begin
        if (dly == 0) begin
          mem_rsp_valid <= 1'b1; mem_rsp_data <= rd(pend_addr); pend <= 1'b0;
        end else dly <= dly - 1;
      end
      if (mem_req_valid) begin
        rd_t e;
        chk(!pend, "R10", "second read while one outstanding", {31'h0, pend}, 32'h0);
        if (rd_q.size() == 0) begin
          chk(1'b0, "R7", "unexpected read", mem_req_addr, 32'h0);
        end else begin
          e = rd_q.pop_front();
          chk(mem_req_addr == e.a, e.first ? "R2" : "R3", "read address", mem_req_addr, e.a);
        end
        pend <= 1'b1; pend_addr <= mem_req_addr; dly <= lat;
      end
    end
  end

  // Result monitor.
  always @(negedge clk) begin
    if (!rst && (done_valid || fault_valid)) begin
      res_t e;
      chk(!(done_valid && fault_valid), "R8", "done and fault together", {31'h0, done_valid}, 32'h0);
      chk(req_ready, "R8", "ready with result", {31'h0, req_ready}, 32'h1);
      if (exp_q.size() == 0) begin
        chk(1'b0, "R8", "result with nothing expected", done_pte, 32'h0);
      end else begin
        e = exp_q.pop_front();
        chk(fault_valid == e.is_fault, e.tag, "fault flag", {31'h0, fault_valid}, {31'h0, e.is_fault});
        if (e.is_fault) begin
          chk(fault_level == e.lvl, e.tag, "fault level", {30'h0, fault_level}, {30'h0, e.lvl});
        end else begin
          chk(done_pte == e.pte, e.tag, "leaf word (R8)", done_pte, e.pte);
          chk(done_level == e.lvl, e.tag, "leaf level (R8)", {30'h0, done_level}, {30'h0, e.lvl});
          chk(done_paddr == e.pa, e.tag, "physical address", done_paddr, e.pa);
        end
      end
    end
  end

  initial begin
    mem_arr[CB + 32'd8]              = 32'h0002_0001;
    mem_arr[32'h0002_0000 + 32'h48]  = 32'h0003_0001;
    mem_arr[32'h0003_0000 + 32'h14]  = 32'h0004_0001;
    mem_arr[32'h0004_0000 + 32'h84]  = 32'hABCD_E0F2;
    mem_arr[32'h0004_0000 + 32'h88]  = 32'h0006_0001;
    mem_arr[32'h0004_0000 + 32'h8C]  = 32'h1234_5003;
    mem_arr[32'h0002_0000 + 32'h200] = 32'h7F00_0002;
    mem_arr[32'h0003_0000 + 32'h18]  = 32'h5555_4006;
    mem_arr[32'h0003_0000 + 32'h20]  = 32'h0000_0000;
    mem_arr[CB + 32'd12]             = 32'h0000_8002;
    mem_arr[CB + 32'd60]             = 32'h0005_0001;
    mem_arr[32'h0005_0000 + 32'h3FC] = 32'h0007_0001;
    mem_arr[32'h0007_0000 + 32'hFC]  = 32'h0008_0001;
    mem_arr[32'h0008_0000 + 32'hFC]  = 32'hFFFF_F00A;

    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(req_ready, "R9", "reset ready", {31'h0, req_ready}, 32'h1);
    chk(!mem_req_valid && !done_valid && !fault_valid, "R9", "reset pulses low",
        {29'h0, mem_req_valid, done_valid, fault_valid}, 32'h0);
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready && !mem_req_valid, "R9", "idle after reset",
        {30'h0, req_ready, mem_req_valid}, 32'h2);

    lat = 0;
    send(4'd2, mkva(8'h12, 6'h05, 6'h21, 12'hABC), "R1");  drain();
    send(4'd2, mkva(8'h80, 6'h2A, 6'h03, 12'h123), "R5");  drain();
    send(4'd2, mkva(8'h12, 6'h06, 6'h09, 12'hFFF), "R5");  drain();
    lat = 3;
    send(4'd2, mkva(8'h12, 6'h07, 6'h00, 12'h000), "R4");  drain();
    send(4'd2, mkva(8'h12, 6'h08, 6'h11, 12'h004), "R4");  drain();
    send(4'd2, mkva(8'h12, 6'h05, 6'h23, 12'h010), "R4");  drain();
    send(4'd2, mkva(8'h12, 6'h05, 6'h22, 12'h020), "R6");  drain();
    send(4'd3, mkva(8'h00, 6'h00, 6'h00, 12'h000), "R6");  drain();
    send(4'd5, mkva(8'h01, 6'h01, 6'h01, 12'h001), "R4");  drain();
    lat = 1;
    send(4'd15, mkva(8'hFF, 6'h3F, 6'h3F, 12'hFFF), "R1"); drain();

    // Back-to-back misses: later valid held while the walker is busy (R7).
    lat = 3;
    send(4'd2, mkva(8'h12, 6'h05, 6'h21, 12'h001), "R7");
    send(4'd2, mkva(8'h80, 6'h00, 6'h00, 12'h002), "R7");
    send(4'd3, mkva(8'h00, 6'h00, 6'h00, 12'h003), "R7");
    lat = 0;
    send(4'd15, mkva(8'hFF, 6'h3F, 6'h3F, 12'h000), "R7");
    drain();
    chk(rd_q.size() == 0, "R10", "all reads consumed", rd_q.size(), 32'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired act=%h exp=%h", exp_q.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule